// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

This block is a single down-counting timer channel that drives one waveform output. Software programs it through a small register-write port. A control word holds three bits: run, reload-from-registers and two-width waveform. Two count registers, one for the low width and one for the high width, complete the register set. A phase programmed with count N lasts N+1 clock cycles, so any width from one cycle up to 2^CNT_W cycles can be reached.

With the two-width waveform selected, the output alternates between a low phase timed by the low-width register and a high phase timed by the high-width register. Without it, only the low-width register is used and the output is a symmetric square wave. If the reload-from-registers bit is clear, every reload takes the all-ones count instead of a register value, and the channel runs free.

Starting the channel always begins a fresh low phase. Stopping it parks the output low and freezes the count. A count register can be rewritten while the channel runs; the new value is picked up at the next reload that uses that register.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the output is 0 and the control word and both count registers read back as 0.
- R2: The control word is at address 0, with bit 0 = run, bit 1 = reload-from-registers and bit 2 = two-width waveform. The low-width count is at address 1 and the high-width count at address 2. All three read back on rd_data the value written; the control word keeps only its three bits.
- R3: On a 0-to-1 change of the run bit, the output is low and goes high exactly LOW+2 cycles after the clock edge that accepts the write. That is one cycle to start, then LOW+1 low cycles.
- R4: While running with reload-from-registers and two-width waveform set, high phases last HIGH+1 cycles and low phases last LOW+1 cycles, alternating.
- R5: While running with reload-from-registers set and two-width waveform clear, both phases last LOW+1 cycles and the high-width register has no effect.
- R6: With reload-from-registers clear, every load, the first one included, takes the all-ones count, so each phase lasts 2^CNT_W cycles.
- R7: A count of 0 gives phases of exactly one cycle, so the output toggles on every clock.
- R8: Writing a count register while running leaves the current phase length unchanged. The next phase that reloads from that register uses the new value.
- R9: When the run bit is cleared, the output is 0 from the second clock edge after the write onward, and the count is held. A later restart begins with a full low phase.
- R10: A write to address 3 changes no register, and address 3 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |
| pwm_o | output | 1 | Waveform output |

## Verification
A count-register write and a reload of the counter can land in the same cycle. The phase that reloads at that edge must still take the old value, and the phase after it must take the new one. The bench provokes this by running both widths at count 0, so that every cycle is a reload, and then rewriting the high-width register. It judges the outcome from the lengths of the output phases that follow. A second test writes mid-phase and checks that the phase in progress keeps its length while the following phases show the new width.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    typedef struct packed {
        logic two_width;
        logic use_regs;
        logic run;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int A_CTRL   = 0;
    localparam int A_LOW    = 1;
    localparam int A_HIGH   = 2;

endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  low_o,
    output logic [CNT_W-1:0]  high_o
);

    localparam int PAD_W = CNT_W - CTRL_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (int'(wr_addr))
                A_CTRL:  regs_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                A_LOW:   regs_d.low  = wr_data;
                A_HIGH:  regs_d.high = wr_data;
                default: regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (int'(rd_addr))
            A_CTRL:  rd_data = {{PAD_W{1'b0}}, regs_q.ctrl};
            A_LOW:   rd_data = regs_q.low;
            A_HIGH:  rd_data = regs_q.high;
            default: rd_data = '0;
        endcase
    end

    assign ctrl_o = regs_q.ctrl;
    assign low_o  = regs_q.low;
    assign high_o = regs_q.high;

endmodule

// File: rtl/pwm_reload_mux.sv
module pwm_reload_mux
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  ctrl_t            ctrl,
    input  logic             to_high,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    output logic [CNT_W-1:0] reload
);

    localparam logic [CNT_W-1:0] FREE_CNT = '1;

    always_comb begin
        if (!ctrl.use_regs)                 reload = FREE_CNT;
        else if (ctrl.two_width && to_high) reload = high_cnt;
        else                                reload = low_cnt;
    end

endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic [CNT_W-1:0] next_cnt,
    output logic             to_high,
    output logic             running,
    output logic             phase,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic             run;
        logic             phase;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    // Phase entered at the next reload: high when the current phase is low.
    assign to_high = ~st_q.phase;

    always_comb begin
        st_d = st_q;
        if (!run_req) begin
            st_d.run   = 1'b0;
            st_d.phase = 1'b0;
        end else if (!st_q.run) begin
            st_d.run   = 1'b1;
            st_d.phase = 1'b0;
            st_d.cnt   = start_cnt;
        end else if (st_q.cnt == '0) begin
            st_d.phase = ~st_q.phase;
            st_d.cnt   = next_cnt;
        end else begin
            st_d.cnt   = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running = st_q.run;
    assign phase   = st_q.phase;
    assign count   = st_q.cnt;

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pwm_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] next_cnt;
    logic             to_high;
    logic             running;
    logic             phase;
    logic [CNT_W-1:0] count;

    pwm_ctrl_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_o  (ctrl),
        .low_o   (low_cnt),
        .high_o  (high_cnt)
    );

    // Start always enters the low phase.
    pwm_reload_mux #(.CNT_W(CNT_W)) u_start_mux (
        .ctrl     (ctrl),
        .to_high  (1'b0),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .reload   (start_cnt)
    );

    pwm_reload_mux #(.CNT_W(CNT_W)) u_next_mux (
        .ctrl     (ctrl),
        .to_high  (to_high),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .reload   (next_cnt)
    );

    pwm_phase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (ctrl.run),
        .start_cnt (start_cnt),
        .next_cnt  (next_cnt),
        .to_high   (to_high),
        .running   (running),
        .phase     (phase),
        .count     (count)
    );

    assign pwm_o = phase;

endmodule

// File: rtl/pwm_reload_timer_chk.sv
module pwm_reload_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_bit,
    input logic             use_regs,
    input logic             two_width,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] low_cnt,
    input logic             pwm_o
);

    // R3: a fresh start always shows the low level
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !pwm_o);

    // R4: inside a phase the count steps down by one per cycle
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(run_bit) && $past(count) != '0)
            |-> count == $past(count) - 1'b1);

    // R7: an expired count flips the output
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(count) == '0)
            |-> pwm_o != $past(pwm_o));

    // R5: symmetric mode reloads from the low-width register only
    p_sym_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(count) == '0
            && $past(use_regs) && !$past(two_width))
            |-> count == $past(low_cnt));

    // R9: stopped channel parks low and holds its count
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pwm_o);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> $stable(count));

endmodule

bind pwm_reload_timer pwm_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_bit   (ctrl.run),
    .use_regs  (ctrl.use_regs),
    .two_width (ctrl.two_width),
    .running   (running),
    .count     (count),
    .low_cnt   (low_cnt),
    .pwm_o     (pwm_o)
);

// File: tb/pwm_reload_timer_tb.sv
module pwm_reload_timer_tb;

    localparam int W  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pwm_reload_timer #(.CNT_W(W), .ADDR_W(AW)) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data), .pwm_o (pwm_o)
    );

    // Phase-length monitor
    logic prev_out = 1'b0;
    int   run_len  = 0;
    int   last_len = 0;
    int   ntrans   = 0;
    always @(negedge clk) begin
        if (pwm_o !== prev_out) begin
            last_len = run_len;
            run_len  = 1;
            prev_out = pwm_o;
            ntrans   = ntrans + 1;
        end else begin
            run_len = run_len + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  low;
        logic [7:0]  high;
        logic [15:0] first;
        logic [15:0] hlen;
        logic [15:0] llen;
    } vec_t;

    // ctrl: bit0 run, bit1 reload-from-registers, bit2 two-width
    localparam vec_t VECS [6] = '{
        '{8'h07, 8'd2, 8'd6, 16'd4,   16'd7,   16'd3},    // R3 R4
        '{8'h07, 8'd0, 8'd3, 16'd2,   16'd4,   16'd1},    // R7 low zero
        '{8'h07, 8'd5, 8'd0, 16'd7,   16'd1,   16'd6},    // R7 high zero
        '{8'h03, 8'd4, 8'd9, 16'd6,   16'd5,   16'd5},    // R5
        '{8'h07, 8'd0, 8'd0, 16'd2,   16'd1,   16'd1},    // R7
        '{8'h05, 8'd2, 8'd6, 16'd257, 16'd256, 16'd256}   // R6
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = W'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic wait_trans(output int len);
        int t0;
        t0 = ntrans;
        while (ntrans == t0) @(posedge clk);
        len = last_len;
    endtask

    task automatic first_low(output int n);
        n = 0;
        while (pwm_o == 1'b0) begin
            n++;
            @(negedge clk);
        end
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int v;
        int n;
        int l1;
        int l2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out", int'(pwm_o), 0);
        rd(0, v); check("R1 ctrl", v, 0);
        rd(1, v); check("R1 low", v, 0);
        rd(2, v); check("R1 high", v, 0);
        rst_n = 1'b1;

        // R2 register layout and readback
        wr(0, 8'hFE); rd(0, v); check("R2 ctrl bits kept", v, 6);
        wr(1, 8'hA5); rd(1, v); check("R2 low", v, 8'hA5);
        wr(2, 8'h3C); rd(2, v); check("R2 high", v, 8'h3C);
        wr(0, 0);

        // R10 unused address
        wr(3, 8'hFF);
        rd(3, v); check("R10 addr3 reads 0", v, 0);
        rd(0, v); check("R10 ctrl untouched", v, 0);
        rd(1, v); check("R10 low untouched", v, 8'hA5);
        rd(2, v); check("R10 high untouched", v, 8'h3C);
        check("R10 out", int'(pwm_o), 0);

        // Vector table
        foreach (VECS[i]) begin
            wr(0, 0);
            wr(1, int'(VECS[i].low));
            wr(2, int'(VECS[i].high));
            wr(0, int'(VECS[i].ctrl));
            first_low(n);
            check($sformatf("R3 vec%0d first low", i), n, int'(VECS[i].first));
            wait_trans(l1);
            check($sformatf("R4 vec%0d high", i), l1, int'(VECS[i].hlen));
            wait_trans(l2);
            check($sformatf("R4 vec%0d low", i), l2, int'(VECS[i].llen));
        end

        // R8 mid-phase rewrite
        wr(0, 0); wr(1, 20); wr(2, 20); wr(0, 7);
        first_low(n);
        wr(2, 5);
        wr(1, 3);
        wait_trans(l1); check("R8 current high kept", l1, 21);
        wait_trans(l1); check("R8 new low", l1, 4);
        wait_trans(l1); check("R8 new high", l1, 6);

        // R8 write coinciding with reloads (one-cycle phases)
        wr(0, 0); wr(1, 0); wr(2, 0); wr(0, 7);
        first_low(n);
        wr(2, 3);
        wait_trans(l1); wait_trans(l1);
        wait_trans(l1); wait_trans(l2);
        check("R8 coincide pair sum", l1 + l2, 5);
        check("R8 coincide high", (l1 > l2) ? l1 : l2, 4);

        // R9 stop and restart
        wr(0, 0); wr(1, 9); wr(2, 9); wr(0, 7);
        first_low(n);
        wr(0, 6);
        @(posedge clk);
        @(negedge clk);
        check("R9 out low after stop", int'(pwm_o), 0);
        repeat (5) @(negedge clk);
        check("R9 still low", int'(pwm_o), 0);
        wr(0, 7);
        first_low(n);
        check("R9 restart full low", n, 11);

        done = 1;
        finish_run();
    end

endmodule